// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access at a time. The request carries the access kind (load, store or instruction fetch), a privilege index, a flag that selects physical addressing, and the base address of the top-level table. Some requests resolve at once, with no table reads: physical bypass, badly sign-extended addresses and the kernel superpage window. Every other request walks a three-level table in memory, with one 64-bit read per level over a simple request/response port.

The walker answers with a one-cycle response. A good translation gives the physical address and the granted rights, coded bit 0 read, bit 1 write, bit 2 execute. A fault gives a fault code and three trap arguments: the address, the code, and the access kind. Fault codes are 0 not-valid, 1 access violation, 2 fault-on-read, 3 fault-on-execute and 4 fault-on-write. Access kinds are 0 load, 1 store, 2 fetch. The walker takes a new request only when it is idle.

Table entry layout:
- bit 0: valid
- bits 3:1: fault-on-read, fault-on-write and fault-on-execute
- bits 11:8: read enables, one per privilege index
- bits 15:12: write enables, one per privilege index
- bits 63:32: page frame number

Top module: `pgw_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, busy, resp_valid and mem_req_valid are low and no table read is issued, even if req_valid is high.
- R2: With req_phys high, the response has no fault, resp_paddr equals the virtual address, resp_prot is 3'b111, and no table read is made.
- R3: If bits 63:43 of the address are not all equal, the result is fault code 1 with no table read.
- R4: A superpage address has bit 63 set and bits 42:41 equal to 2'b10. Privilege index 0 gets all rights, and the physical address is bits 39:0 with address bit 40 placed at bit 43. Any other privilege index gets fault code 1. No table read is made.
- R5: A walk reads one 8-byte entry per level, at table base plus 8 times the index. The level indices are bits 42:33, 32:23 and 22:13. The base starts at req_ptbr, and each next base is entry bits 63:32 shifted left by 13. A good walk makes three reads, and gives entry bits 63:32 shifted left by 13, ORed with address bits 12:0.
- R6: At level 1 or level 2, an entry with bit 0 clear ends the walk with code 0. An entry with bit 8 clear ends the walk with code 1. No further reads follow the faulting read.
- R7: At level 3, an entry with bit 0 clear gives code 0. Read and execute rights come from bit 8+priv, and write right from bit 12+priv. If the needed right is missing, the result is code 1. Load needs read, store needs write and fetch needs execute.
- R8: After the rights check, entry bit 1 removes read, bit 2 removes write and bit 3 removes execute. If this removes the needed right, the result is code 3 for a fetch, 4 for a store or 2 for a load. On success, resp_prot reports the rights that remain.
- R9: On a fault, trap_arg0 is the address and trap_arg1 is the code. trap_arg2 is 0 for a load, 1 for a store and all ones for a fetch. resp_paddr and resp_prot are zero. On success all three trap arguments are zero.
- R10: resp_valid is a one-cycle pulse. A request that resolves at once answers in the cycle after it is accepted. A request raised while busy is ignored: it starts no walk and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Privilege index, 0 is kernel |
| req_phys | input | 1 | Physical addressing, bypass translation |
| req_ptbr | input | 64 | Base address of the level-1 table |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 64 | Address of the entry to read |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table entry read |
| busy | output | 1 | High from acceptance through the response cycle |
| resp_valid | output | 1 | One-cycle response |
| resp_fault | output | 1 | Response is a fault |
| resp_paddr | output | 64 | Physical address |
| resp_prot | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| trap_arg0 | output | 64 | Faulting address |
| trap_arg1 | output | 64 | Fault code |
| trap_arg2 | output | 64 | Access kind of the faulting access |

## Verification
The checker assumes that memory gives exactly one mem_rsp_valid pulse per read, and only while the walker waits for it, never in the cycle in which the read is issued. Its check that an invalid entry stops the walk relies on this. The bench memory model keeps to it: it answers one cycle after it sees mem_req_valid and stays silent otherwise. The request inputs matter only in the cycle a request is accepted. The bench changes them only at the falling edge and holds them around the accepting edge.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int XLEN        = 64;
    localparam int PG_BITS_D   = 13;
    localparam int IDX_W_D     = 10;
    localparam int LEVELS_D    = 3;
    localparam int IMPL_VA_D   = 43;
    localparam int PRIV_W      = 2;
    localparam int ACC_W       = 2;
    localparam int PROT_W      = 3;
    localparam int ENTRY_SHIFT = 3;

    // entry bit positions
    localparam int PTE_V       = 0;
    localparam int PTE_FOR     = 1;
    localparam int PTE_FOE     = 3;
    localparam int PTE_RE_LSB  = 8;
    localparam int PTE_WE_LSB  = PTE_RE_LSB + (1 << PRIV_W);
    localparam int PTE_PFN_LSB = 32;

    // superpage window
    localparam int SP_SEL_LSB  = 41;
    localparam int SP_HOLE_BIT = 40;
    localparam int SP_MOVE_BIT = 43;

    // rights bits
    localparam int PROT_R = 0;
    localparam int PROT_W_BIT = 1;
    localparam int PROT_X = 2;

    typedef enum logic [2:0] {
        FLT_TNV = 3'd0,
        FLT_ACV = 3'd1,
        FLT_FOR = 3'd2,
        FLT_FOE = 3'd3,
        FLT_FOW = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic              fault;
        fault_e            code;
        logic [XLEN-1:0]   paddr;
        logic [PROT_W-1:0] prot;
    } xlat_t;

    function automatic logic [PROT_W-1:0] need_of(input logic [ACC_W-1:0] acc);
        case (acc)
            2'd0:    need_of = 3'b001;
            2'd1:    need_of = 3'b010;
            default: need_of = 3'b100;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] trap_kind(input logic [ACC_W-1:0] acc);
        case (acc)
            2'd0:    trap_kind = '0;
            2'd1:    trap_kind = XLEN'(1);
            default: trap_kind = '1;
        endcase
    endfunction

    function automatic xlat_t fault_res(input fault_e c);
        xlat_t r;
        r.fault = 1'b1;
        r.code  = c;
        r.paddr = '0;
        r.prot  = '0;
        return r;
    endfunction

    function automatic xlat_t ok_res(input logic [XLEN-1:0] pa, input logic [PROT_W-1:0] pr);
        xlat_t r;
        r.fault = 1'b0;
        r.code  = FLT_TNV;
        r.paddr = pa;
        r.prot  = pr;
        return r;
    endfunction
endpackage

// File: rtl/pgw_classify.sv
module pgw_classify
    import pgw_pkg::*;
#(
    parameter int IMPL_VA = IMPL_VA_D
) (
    input  logic [XLEN-1:0]   vaddr,
    input  logic              phys_mode,
    input  logic [PRIV_W-1:0] priv,
    output logic              is_walk,
    output xlat_t             res
);
    logic            canon;
    logic            in_sp;
    logic [XLEN-1:0] sp_pa;

    always_comb begin
        canon = (&vaddr[XLEN-1:IMPL_VA]) | ~(|vaddr[XLEN-1:IMPL_VA]);
        in_sp = vaddr[XLEN-1] && (vaddr[SP_SEL_LSB+1:SP_SEL_LSB] == 2'b10);
        sp_pa = '0;
        sp_pa[SP_HOLE_BIT-1:0] = vaddr[SP_HOLE_BIT-1:0];
        sp_pa[SP_MOVE_BIT]     = vaddr[SP_HOLE_BIT];

        is_walk = 1'b0;
        res     = ok_res(vaddr, 3'b111);
        if (phys_mode) begin
            res = ok_res(vaddr, 3'b111);
        end else if (!canon) begin
            res = fault_res(FLT_ACV);
        end else if (in_sp) begin
            if (priv != '0) res = fault_res(FLT_ACV);
            else            res = ok_res(sp_pa, 3'b111);
        end else begin
            is_walk = 1'b1;
            res     = fault_res(FLT_TNV);
        end
    end
endmodule

// File: rtl/pgw_index.sv
module pgw_index
    import pgw_pkg::*;
#(
    parameter int IDX_W  = IDX_W_D,
    parameter int LEVELS = LEVELS_D,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        lvl,
    input  logic [XLEN-1:0]         base,
    output logic [XLEN-1:0]         addr
);
    localparam int SLOTS = 1 << LVL_W;

    logic [IDX_W-1:0] idx_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < LEVELS) begin : g_used
            assign idx_arr[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
        end else begin : g_pad
            assign idx_arr[g] = '0;
        end
    end

    assign addr = base + (XLEN'(idx_arr[lvl]) << ENTRY_SHIFT);
endmodule

// File: rtl/pgw_leaf.sv
module pgw_leaf
    import pgw_pkg::*;
#(
    parameter int PG_BITS = PG_BITS_D
) (
    input  logic [XLEN-1:0]    pte,
    input  logic [PRIV_W-1:0]  priv,
    input  logic [ACC_W-1:0]   acc,
    input  logic [PG_BITS-1:0] voff,
    output xlat_t              res
);
    logic [PROT_W-1:0] need;
    logic [PROT_W-1:0] granted;
    logic [PROT_W-1:0] masked;
    logic [XLEN-1:0]   pa;
    logic              re_bit;
    logic              we_bit;
    logic              unused_pte;

    assign unused_pte = ^{pte[PTE_RE_LSB-1:PTE_FOE+1],
                          pte[PTE_PFN_LSB-1:PTE_WE_LSB+(1<<PRIV_W)]};

    always_comb begin
        need    = need_of(acc);
        re_bit  = pte[PTE_RE_LSB + 32'(priv)];
        we_bit  = pte[PTE_WE_LSB + 32'(priv)];
        granted = {re_bit, we_bit, re_bit};
        masked  = granted & ~pte[PTE_FOE:PTE_FOR];
        pa      = (XLEN'(pte[XLEN-1:PTE_PFN_LSB]) << PG_BITS) | XLEN'(voff);

        if (!pte[PTE_V]) begin
            res = fault_res(FLT_TNV);
        end else if ((granted & need) == '0) begin
            res = fault_res(FLT_ACV);
        end else if ((masked & need) == '0) begin
            if (need[PROT_X])          res = fault_res(FLT_FOE);
            else if (need[PROT_W_BIT]) res = fault_res(FLT_FOW);
            else                       res = fault_res(FLT_FOR);
        end else begin
            res = ok_res(pa, masked);
        end
    end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
#(
    parameter int IMPL_VA = IMPL_VA_D,
    parameter int PG_BITS = PG_BITS_D,
    parameter int IDX_W   = IDX_W_D,
    parameter int LEVELS  = LEVELS_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [XLEN-1:0]   req_vaddr,
    input  logic [ACC_W-1:0]  req_acc,
    input  logic [PRIV_W-1:0] req_priv,
    input  logic              req_phys,
    input  logic [XLEN-1:0]   req_ptbr,
    output logic              mem_req_valid,
    output logic [XLEN-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [XLEN-1:0]   resp_paddr,
    output logic [PROT_W-1:0] resp_prot,
    output logic [XLEN-1:0]   trap_arg0,
    output logic [XLEN-1:0]   trap_arg1,
    output logic [XLEN-1:0]   trap_arg2
);
    localparam int             LVL_W    = $clog2(LEVELS);
    localparam int             VPN_W    = LEVELS * IDX_W;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_st_e          state_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [XLEN-1:0]   va_q;
    logic [ACC_W-1:0]  acc_q;
    logic [PRIV_W-1:0] priv_q;
    logic [XLEN-1:0]   base_q;
    xlat_t             res_q;

    logic              cls_walk;
    xlat_t             cls_res;
    xlat_t             leaf_res;
    logic [XLEN-1:0]   next_base;

    pgw_classify #(.IMPL_VA(IMPL_VA)) u_cls (
        .vaddr     (req_vaddr),
        .phys_mode (req_phys),
        .priv      (req_priv),
        .is_walk   (cls_walk),
        .res       (cls_res)
    );

    pgw_index #(.IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_idx (
        .vpn  (va_q[PG_BITS+VPN_W-1:PG_BITS]),
        .lvl  (lvl_q),
        .base (base_q),
        .addr (mem_req_addr)
    );

    pgw_leaf #(.PG_BITS(PG_BITS)) u_leaf (
        .pte  (mem_rsp_data),
        .priv (priv_q),
        .acc  (acc_q),
        .voff (va_q[PG_BITS-1:0]),
        .res  (leaf_res)
    );

    assign next_base = XLEN'(mem_rsp_data[XLEN-1:PTE_PFN_LSB]) << PG_BITS;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            va_q    <= '0;
            acc_q   <= '0;
            priv_q  <= '0;
            base_q  <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        acc_q  <= req_acc;
                        priv_q <= req_priv;
                        base_q <= req_ptbr;
                        lvl_q  <= '0;
                        if (cls_walk) begin
                            state_q <= ST_ISSUE;
                        end else begin
                            res_q   <= cls_res;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (lvl_q == LAST_LVL) begin
                            res_q   <= leaf_res;
                            state_q <= ST_DONE;
                        end else if (!mem_rsp_data[PTE_V]) begin
                            res_q   <= fault_res(FLT_TNV);
                            state_q <= ST_DONE;
                        end else if (!mem_rsp_data[PTE_RE_LSB]) begin
                            res_q   <= fault_res(FLT_ACV);
                            state_q <= ST_DONE;
                        end else begin
                            base_q  <= next_base;
                            lvl_q   <= lvl_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (state_q == ST_ISSUE);
    assign busy          = (state_q != ST_IDLE);
    assign resp_valid    = (state_q == ST_DONE);
    assign resp_fault    = res_q.fault;
    assign resp_paddr    = res_q.paddr;
    assign resp_prot     = res_q.prot;
    assign trap_arg0     = res_q.fault ? va_q : '0;
    assign trap_arg1     = res_q.fault ? XLEN'(res_q.code) : '0;
    assign trap_arg2     = res_q.fault ? trap_kind(acc_q) : '0;
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk
    import pgw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [XLEN-1:0]   req_vaddr,
    input logic              req_phys,
    input logic              mem_req_valid,
    input logic              mem_rsp_valid,
    input logic [XLEN-1:0]   mem_rsp_data,
    input logic              busy,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [XLEN-1:0]   resp_paddr,
    input logic [PROT_W-1:0] resp_prot,
    input logic [XLEN-1:0]   trap_arg0,
    input logic [XLEN-1:0]   trap_arg1,
    input logic [XLEN-1:0]   trap_arg2
);
    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R5
    mem_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req_valid && !resp_valid));

    // R2
    phys_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_phys) |=>
        (resp_valid && !resp_fault && resp_paddr == $past(req_vaddr) && resp_prot == 3'b111));

    // R6
    invalid_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && !mem_rsp_data[PTE_V]) |=>
        (resp_valid && resp_fault && trap_arg1 == '0));

    // R9
    fault_args_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |->
        (resp_prot == '0 && resp_paddr == '0 && trap_arg1 <= XLEN'(4)));

    // R8
    grant_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |->
        (resp_prot != '0 && trap_arg0 == '0 && trap_arg1 == '0 && trap_arg2 == '0));
endmodule

bind pgw_top pgw_chk u_chk (.*);

// File: tb/sim_pgw_top.sv
`timescale 1ns/1ps
module sim_pgw_top;
    localparam real CLK_NS = 20.0;
    localparam logic [63:0] PTBR = 64'h0000_0000_0010_0000;

    typedef struct packed {
        logic [63:0] va;
        logic [1:0]  acc;
        logic [1:0]  priv;
        logic        phys;
        logic        ef;
        logic [2:0]  ecode;
        logic [63:0] epa;
        logic [2:0]  eprot;
        logic [1:0]  ereads;
        logic [3:0]  rtag;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R2 bypass
        '{64'hDEAD_BEEF_0000_1234, 2'd1, 2'd1, 1'b1, 1'b0, 3'd0, 64'hDEAD_BEEF_0000_1234, 3'd7, 2'd0, 4'd2},
        // R3 bad extension, positive
        '{64'h0000_1000_0000_0000, 2'd0, 2'd0, 1'b0, 1'b1, 3'd1, 64'h0, 3'd0, 2'd0, 4'd3},
        // R3 bad extension, negative
        '{64'h8000_0000_0000_0000, 2'd1, 2'd0, 1'b0, 1'b1, 3'd1, 64'h0, 3'd0, 2'd0, 4'd3},
        // R4 superpage kernel, bit 40 moves to 43
        '{64'hFFFF_FD12_3456_789A, 2'd2, 2'd0, 1'b0, 1'b0, 3'd0, 64'h0000_0812_3456_789A, 3'd7, 2'd0, 4'd4},
        // R4 superpage non-kernel
        '{64'hFFFF_FD12_3456_789A, 2'd2, 2'd1, 1'b0, 1'b1, 3'd1, 64'h0, 3'd0, 2'd0, 4'd4},
        // R4 superpage, bit 40 clear
        '{64'hFFFF_FC00_0000_2000, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 64'h0000_0000_0000_2000, 3'd7, 2'd0, 4'd4},
        // R5 full walk, kernel load
        '{64'h0000_0002_0100_01A5, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 64'h0000_0000_0246_81A5, 3'd7, 2'd3, 4'd5},
        // R7 user store, no user write
        '{64'h0000_0002_0100_01A5, 2'd1, 2'd1, 1'b0, 1'b1, 3'd1, 64'h0, 3'd0, 2'd3, 4'd7},
        // R7 user load
        '{64'h0000_0002_0100_01A5, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0, 64'h0000_0000_0246_81A5, 3'd5, 2'd3, 4'd7},
        // R7 leaf invalid
        '{64'h0000_0002_0100_2000, 2'd0, 2'd0, 1'b0, 1'b1, 3'd0, 64'h0, 3'd0, 2'd3, 4'd7},
        // R7 kernel store, read only
        '{64'h0000_0002_0100_4008, 2'd1, 2'd0, 1'b0, 1'b1, 3'd1, 64'h0, 3'd0, 2'd3, 4'd7},
        // R8 fault on write
        '{64'h0000_0002_0100_6010, 2'd1, 2'd0, 1'b0, 1'b1, 3'd4, 64'h0, 3'd0, 2'd3, 4'd8},
        // R8 load through write-masked page
        '{64'h0000_0002_0100_6010, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 64'h0000_0000_000C_C010, 3'd5, 2'd3, 4'd8},
        // R8 fault on execute
        '{64'h0000_0002_0100_8020, 2'd2, 2'd0, 1'b0, 1'b1, 3'd3, 64'h0, 3'd0, 2'd3, 4'd8},
        // R8 load through execute-masked page
        '{64'h0000_0002_0100_8020, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 64'h0000_0000_000E_E020, 3'd1, 2'd3, 4'd8},
        // R8 fault on read
        '{64'h0000_0002_0100_A040, 2'd0, 2'd0, 1'b0, 1'b1, 3'd2, 64'h0, 3'd0, 2'd3, 4'd8},
        // R6 level 1 invalid
        '{64'h0000_0000_0000_0100, 2'd2, 2'd0, 1'b0, 1'b1, 3'd0, 64'h0, 3'd0, 2'd1, 4'd6},
        // R6 level 1 no read enable
        '{64'h0000_0006_0000_0000, 2'd0, 2'd0, 1'b0, 1'b1, 3'd1, 64'h0, 3'd0, 2'd1, 4'd6},
        // R6 level 2 invalid
        '{64'h0000_0002_0280_0000, 2'd1, 2'd0, 1'b0, 1'b1, 3'd0, 64'h0, 3'd0, 2'd2, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic [1:0]  req_acc;
    logic [1:0]  req_priv;
    logic        req_phys;
    logic [63:0] req_ptbr;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        busy;
    logic        resp_valid;
    logic        resp_fault;
    logic [63:0] resp_paddr;
    logic [2:0]  resp_prot;
    logic [63:0] trap_arg0;
    logic [63:0] trap_arg1;
    logic [63:0] trap_arg2;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;

    always #(CLK_NS/2) clk = ~clk;

    pgw_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_priv(req_priv), .req_phys(req_phys), .req_ptbr(req_ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_paddr(resp_paddr), .resp_prot(resp_prot),
        .trap_arg0(trap_arg0), .trap_arg1(trap_arg1), .trap_arg2(trap_arg2)
    );

    function automatic logic [63:0] mem_read(input logic [63:0] a);
        case (a)
            64'h10_0008: mem_read = 64'h0000_0200_0000_0101;
            64'h10_0018: mem_read = 64'h0000_0000_0000_0001;
            64'h40_0010: mem_read = 64'h0000_0300_0000_0101;
            64'h60_0000: mem_read = 64'h0000_1234_0000_1301;
            64'h60_0010: mem_read = 64'h0000_0055_0000_0101;
            64'h60_0018: mem_read = 64'h0000_0066_0000_1105;
            64'h60_0020: mem_read = 64'h0000_0077_0000_0109;
            64'h60_0028: mem_read = 64'h0000_0088_0000_0103;
            default:     mem_read = 64'h0;
        endcase
    endfunction

    // memory model: answers one cycle after each read request
    initial begin
        logic [63:0] a;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                rd_cnt++;
                a = mem_req_addr;
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_read(a);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input vec_t v, output bit seen);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = v.va;
        req_acc   = v.acc;
        req_priv  = v.priv;
        req_phys  = v.phys;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 1'b0;
        for (int t = 0; t < 50; t++) begin
            if (resp_valid) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        int r0;
        string tg;
        logic [63:0] e0, e1, e2;
        vec_t w;

        rst = 1'b1;
        req_valid = 1'b1;
        req_vaddr = 64'h0000_0002_0100_01A5;
        req_acc = 2'd0;
        req_priv = 2'd0;
        req_phys = 1'b0;
        req_ptbr = PTBR;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !resp_valid && !mem_req_valid, "R1", "outputs after reset",
              {61'b0, busy, resp_valid, mem_req_valid}, 64'h0);
        check(rd_cnt == 0, "R1", "reads during reset", 64'(rd_cnt), 64'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v  = VECS[i];
            tg = $sformatf("R%0d vec%0d", v.rtag, i);
            r0 = rd_cnt;
            do_req(v, seen);
            check(seen, tg, "response seen", 64'(seen), 64'h1);
            if (seen) begin
                e0 = v.ef ? v.va : 64'h0;
                e1 = v.ef ? 64'(v.ecode) : 64'h0;
                e2 = !v.ef ? 64'h0 : (v.acc == 2'd0) ? 64'h0 : (v.acc == 2'd1) ? 64'h1 : '1;
                check(resp_fault == v.ef, tg, "fault", 64'(resp_fault), 64'(v.ef));
                check(resp_paddr == v.epa, tg, "paddr", resp_paddr, v.epa);
                check(resp_prot == v.eprot, tg, "prot", 64'(resp_prot), 64'(v.eprot));
                // R9 trap arguments
                check(trap_arg0 == e0, tg, "trap_arg0 (R9)", trap_arg0, e0);
                check(trap_arg1 == e1, tg, "trap_arg1 (R9)", trap_arg1, e1);
                check(trap_arg2 == e2, tg, "trap_arg2 (R9)", trap_arg2, e2);
                check((rd_cnt - r0) == int'(v.ereads), tg, "table reads",
                      64'(rd_cnt - r0), 64'(v.ereads));
            end
        end

        // R10 request while busy is ignored; response is a single pulse
        w = VECS[6];
        r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = w.va;
        req_acc = w.acc;
        req_priv = w.priv;
        req_phys = 1'b0;
        @(negedge clk);
        req_vaddr = 64'h0000_0000_0000_0055;
        req_phys = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_phys = 1'b0;
        seen = 1'b0;
        for (int t = 0; t < 50; t++) begin
            if (resp_valid) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(seen && resp_paddr == w.epa, "R10", "busy request ignored, paddr",
              resp_paddr, w.epa);
        @(negedge clk);
        check(!resp_valid, "R10", "response pulse width", 64'(resp_valid), 64'h0);
        seen = 1'b0;
        for (int t = 0; t < 6; t++) begin
            if (resp_valid || busy) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R10", "no second response", 64'(seen), 64'h0);
        check((rd_cnt - r0) == 3, "R10", "reads for one walk", 64'(rd_cnt - r0), 64'h3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule